// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block turns a single maintenance command into the stream of per-line cache operations that a single-level data cache needs. A command can apply to the whole cache or to an address range. Whole-cache commands invalidate, clean, or clean-and-invalidate. Range commands do the same three things, given a start address and a byte count. For whole-cache work the block takes the cache shape from a size-identification word. It captures that word when the command is accepted, then visits every set and way. For range work it walks the range one 32-byte line at a time. It presents one operation per cycle on a valid/ready output. The output stalls for as long as the consumer holds ready low, and an offered operation does not change until it is taken.

The block also owns the instruction-cache enable bit and the data-cache enable bit. Each enable or disable command runs the ordering that keeps the cache coherent around the switch. After the last operation of any command has been taken, the block raises a barrier request and holds it until it is acknowledged. It then pulses a completion strobe for one cycle. While a command is in progress the block refuses new commands.

Top module: `dcmaint_seq`

## Requirements
- R1: After reset, `dc_en`, `ic_en`, `op_valid`, `bar_req`, `done` and `busy` are 0 and `cmd_ready` is 1.
- R2: `geom_sel` holds the cache level minus one in bits [3:1] and 0 (data/unified) in bit 0. With the default level this is 4'b0000. A whole-cache command issues exactly (S+1)*(W+1) operations, where S is `geom_word`[27:13] and W is `geom_word`[12:3], both captured when the command is accepted. The set index is the outer loop and the way index is the inner loop.
- R3: A set/way operation word carries the way index in bits [31:30] and the set index in bits [13:5]. Each index is truncated to that field's width (way modulo 4, set modulo 512). All other bits are 0.
- R4: A range command issues floor(size/32) operations. The first address is the start address with bits [4:0] cleared, and each following address is 32 higher. A size below 32 issues no operation, and the command still completes.
- R5: Command codes: 0 invalidate-all, 1 clean-all, 2 clean-and-invalidate-all, 3/4/5 the same three operations by range, 6 data cache on, 7 data cache off, 8 instruction cache on, 9 instruction cache off, 10 instruction-cache invalidate-all. Operation codes on `op_kind`: 1/2/3 invalidate/clean/clean-and-invalidate by set/way, 4/5/6 the same three by address, 7 instruction-cache invalidate-all with word 0. Unassigned command codes issue nothing and complete.
- R6: Data cache on, when `dc_en` is 0, issues a full invalidate by set/way with `dc_en` still 0. `dc_en` goes to 1 only after the last of those operations is taken. When `dc_en` is already 1 the command issues nothing and leaves `dc_en` unchanged.
- R7: Data cache off, when `dc_en` is 1, drops `dc_en` before the first operation. It then issues a full clean-and-invalidate by set/way. When `dc_en` is already 0 the command issues nothing.
- R8: Instruction cache on, when `ic_en` is 0, issues one instruction-cache invalidate-all and then sets `ic_en`. Instruction cache off, when `ic_en` is 1, clears `ic_en` and then issues that operation. Either command issues nothing if `ic_en` already has the target value.
- R9: While `op_valid` is 1 and `op_ready` is 0, the offered `op_kind` and `op_word` hold steady and `op_valid` stays 1.
- R10: After the last operation is taken (or at once if there is none), `bar_req` rises with `op_valid` low. `bar_req` stays high until the first cycle `bar_ack` is seen. `done` then pulses for exactly one cycle.
- R11: `busy` is 1 and `cmd_ready` is 0 from acceptance until `done`. A command offered in that time is ignored and issues no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_code | input | 4 | Command code (R5) |
| cmd_addr | input | 32 | Range start address |
| cmd_size | input | 32 | Range size in bytes |
| geom_sel | output | 4 | Cache selection for the geometry read |
| geom_word | input | 32 | Size-identification word (set and way counts) |
| op_valid | output | 1 | Maintenance operation offered |
| op_ready | input | 1 | Consumer takes the offered operation |
| op_kind | output | 3 | Operation code (R5) |
| op_word | output | 32 | Set/way word or line address |
| bar_req | output | 1 | Barrier request after the final operation |
| bar_ack | input | 1 | Barrier acknowledge |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Command in progress |
| dc_en | output | 1 | Data cache enable |
| ic_en | output | 1 | Instruction cache enable |

## Verification
The checker assumes that `bar_ack` is only sampled while `bar_req` is high. It also assumes that `geom_word` is stable when a command is accepted, because the geometry is captured in that cycle. The bench drives `bar_ack` only after seeing `bar_req` for three cycles. It sets `geom_word` before it offers each command and leaves it alone while the command runs. It drives `op_ready` under three back-pressure patterns. It offers a command while busy only once, and drops that command after one cycle.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    CMD_INV_ALL = 4'd0,
    CMD_CLN_ALL = 4'd1,
    CMD_CI_ALL  = 4'd2,
    CMD_INV_RNG = 4'd3,
    CMD_CLN_RNG = 4'd4,
    CMD_CI_RNG  = 4'd5,
    CMD_DC_ON   = 4'd6,
    CMD_DC_OFF  = 4'd7,
    CMD_IC_ON   = 4'd8,
    CMD_IC_OFF  = 4'd9,
    CMD_IC_INV  = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_INV_SW = 3'd1,
    OP_CLN_SW = 3'd2,
    OP_CI_SW  = 3'd3,
    OP_INV_VA = 3'd4,
    OP_CLN_VA = 3'd5,
    OP_CI_VA  = 3'd6,
    OP_IC_INV = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    WK_SW  = 2'd0,
    WK_VA  = 2'd1,
    WK_ONE = 2'd2
  } walk_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_BAR  = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

  typedef struct packed {
    walk_e walk;
    op_e   kind;
    logic  has_ops;
    logic  set_dc;
    logic  clr_dc;
    logic  set_ic;
    logic  clr_ic;
  } plan_t;
endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
  import dcm_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       dc_en,
  input  logic       ic_en,
  output plan_t      plan
);
  always_comb begin
    plan.walk    = WK_SW;
    plan.kind    = OP_NONE;
    plan.has_ops = 1'b0;
    plan.set_dc  = 1'b0;
    plan.clr_dc  = 1'b0;
    plan.set_ic  = 1'b0;
    plan.clr_ic  = 1'b0;
    case (cmd)
      CMD_INV_ALL: begin plan.kind = OP_INV_SW; plan.has_ops = 1'b1; end
      CMD_CLN_ALL: begin plan.kind = OP_CLN_SW; plan.has_ops = 1'b1; end
      CMD_CI_ALL:  begin plan.kind = OP_CI_SW;  plan.has_ops = 1'b1; end
      CMD_INV_RNG: begin plan.walk = WK_VA; plan.kind = OP_INV_VA; plan.has_ops = 1'b1; end
      CMD_CLN_RNG: begin plan.walk = WK_VA; plan.kind = OP_CLN_VA; plan.has_ops = 1'b1; end
      CMD_CI_RNG:  begin plan.walk = WK_VA; plan.kind = OP_CI_VA;  plan.has_ops = 1'b1; end
      CMD_DC_ON: begin
        if (!dc_en) begin
          plan.kind    = OP_INV_SW;
          plan.has_ops = 1'b1;
          plan.set_dc  = 1'b1;
        end
      end
      CMD_DC_OFF: begin
        if (dc_en) begin
          plan.kind    = OP_CI_SW;
          plan.has_ops = 1'b1;
          plan.clr_dc  = 1'b1;
        end
      end
      CMD_IC_ON: begin
        if (!ic_en) begin
          plan.walk    = WK_ONE;
          plan.kind    = OP_IC_INV;
          plan.has_ops = 1'b1;
          plan.set_ic  = 1'b1;
        end
      end
      CMD_IC_OFF: begin
        if (ic_en) begin
          plan.walk    = WK_ONE;
          plan.kind    = OP_IC_INV;
          plan.has_ops = 1'b1;
          plan.clr_ic  = 1'b1;
        end
      end
      CMD_IC_INV: begin
        plan.walk    = WK_ONE;
        plan.kind    = OP_IC_INV;
        plan.has_ops = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
  import dcm_pkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int SET_LSB     = 13,
  parameter int SET_W       = 15,
  parameter int WAY_LSB     = 3,
  parameter int WAY_W       = 10,
  parameter int SW_SET_POS  = 5,
  parameter int SW_SET_BITS = 9,
  parameter int SW_WAY_POS  = 30,
  parameter int SW_WAY_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  walk_e             mode,
  input  logic [WORD_W-1:0] geom,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] size,
  input  logic              adv,
  output logic [WORD_W-1:0] word,
  output logic              last,
  output logic              empty
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int CNT_W   = WORD_W - LINE_SH;

  walk_e              mode_q;
  logic [SET_W-1:0]   nsets_m1, set_q;
  logic [WAY_W-1:0]   nways_m1, way_q;
  logic [WORD_W-1:0]  addr_q;
  logic [CNT_W-1:0]   remain_q;

  logic unused_bits;
  assign unused_bits = ^{geom[WORD_W-1:SET_LSB+SET_W], geom[WAY_LSB-1:0],
                         base[LINE_SH-1:0], size[LINE_SH-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= WK_SW;
      nsets_m1 <= '0;
      nways_m1 <= '0;
      set_q    <= '0;
      way_q    <= '0;
      addr_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      mode_q   <= mode;
      nsets_m1 <= geom[SET_LSB +: SET_W];
      nways_m1 <= geom[WAY_LSB +: WAY_W];
      set_q    <= '0;
      way_q    <= '0;
      addr_q   <= {base[WORD_W-1:LINE_SH], {LINE_SH{1'b0}}};
      remain_q <= size[WORD_W-1:LINE_SH];
    end else if (adv) begin
      case (mode_q)
        WK_SW: begin
          if (way_q == nways_m1) begin
            way_q <= '0;
            set_q <= set_q + 1'b1;
          end else begin
            way_q <= way_q + 1'b1;
          end
        end
        WK_VA: begin
          addr_q   <= addr_q + WORD_W'(LINE_BYTES);
          remain_q <= remain_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    word = '0;
    case (mode_q)
      WK_SW: begin
        word[SW_WAY_POS +: SW_WAY_BITS] = way_q[SW_WAY_BITS-1:0];
        word[SW_SET_POS +: SW_SET_BITS] = set_q[SW_SET_BITS-1:0];
      end
      WK_VA:   word = addr_q;
      default: word = '0;
    endcase
  end

  always_comb begin
    case (mode_q)
      WK_SW:   last = (set_q == nsets_m1) && (way_q == nways_m1);
      WK_VA:   last = (remain_q == CNT_W'(1));
      default: last = 1'b1;
    endcase
  end

  assign empty = (mode_q == WK_VA) && (remain_q == '0);
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  op_e  plan_kind,
  input  logic plan_has_ops,
  input  logic plan_set_dc,
  input  logic plan_clr_dc,
  input  logic plan_set_ic,
  input  logic plan_clr_ic,
  input  logic walk_last,
  input  logic walk_empty,
  input  logic op_ready,
  input  logic bar_ack,
  output logic op_valid,
  output op_e  op_kind,
  output logic adv,
  output logic bar_req,
  output logic done,
  output logic busy,
  output logic cmd_ready,
  output logic dc_en,
  output logic ic_en
);
  state_e state;
  op_e    kind_q;
  logic   has_ops_q, set_dc_q, set_ic_q, dc_q, ic_q;
  logic   run_end;

  assign op_valid  = (state == ST_RUN) && has_ops_q && !walk_empty;
  assign adv       = op_valid && op_ready;
  assign run_end   = !has_ops_q || walk_empty || (adv && walk_last);
  assign op_kind   = kind_q;
  assign bar_req   = (state == ST_BAR);
  assign done      = (state == ST_FIN);
  assign busy      = (state != ST_IDLE);
  assign cmd_ready = (state == ST_IDLE);
  assign dc_en     = dc_q;
  assign ic_en     = ic_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= OP_NONE;
      has_ops_q <= 1'b0;
      set_dc_q  <= 1'b0;
      set_ic_q  <= 1'b0;
      dc_q      <= 1'b0;
      ic_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            state     <= ST_RUN;
            kind_q    <= plan_kind;
            has_ops_q <= plan_has_ops;
            set_dc_q  <= plan_set_dc;
            set_ic_q  <= plan_set_ic;
            if (plan_clr_dc) dc_q <= 1'b0;
            if (plan_clr_ic) ic_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (run_end) begin
            state <= ST_BAR;
            if (set_dc_q) dc_q <= 1'b1;
            if (set_ic_q) ic_q <= 1'b1;
          end
        end
        ST_BAR: if (bar_ack) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcmaint_seq.sv
module dcmaint_seq
  import dcm_pkg::*;
#(
  parameter int LINE_BYTES  = 32,
  parameter int CACHE_LEVEL = 1,
  parameter int SET_LSB     = 13,
  parameter int SET_W       = 15,
  parameter int WAY_LSB     = 3,
  parameter int WAY_W       = 10,
  parameter int SW_SET_POS  = 5,
  parameter int SW_SET_BITS = 9,
  parameter int SW_WAY_POS  = 30,
  parameter int SW_WAY_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_code,
  input  logic [31:0] cmd_addr,
  input  logic [31:0] cmd_size,
  output logic [3:0]  geom_sel,
  input  logic [31:0] geom_word,
  output logic        op_valid,
  input  logic        op_ready,
  output logic [2:0]  op_kind,
  output logic [31:0] op_word,
  output logic        bar_req,
  input  logic        bar_ack,
  output logic        done,
  output logic        busy,
  output logic        dc_en,
  output logic        ic_en
);
  localparam logic [2:0] LEVEL_FIELD = 3'(CACHE_LEVEL - 1);

  plan_t plan;
  op_e   kind_w;
  logic  cmd_fire, adv, walk_last, walk_empty;

  assign geom_sel = {LEVEL_FIELD, 1'b0};
  assign cmd_fire = cmd_valid && cmd_ready;
  assign op_kind  = kind_w;

  dcm_decode u_decode (
    .cmd   (cmd_code),
    .dc_en (dc_en),
    .ic_en (ic_en),
    .plan  (plan)
  );

  dcm_walker #(
    .LINE_BYTES  (LINE_BYTES),
    .SET_LSB     (SET_LSB),
    .SET_W       (SET_W),
    .WAY_LSB     (WAY_LSB),
    .WAY_W       (WAY_W),
    .SW_SET_POS  (SW_SET_POS),
    .SW_SET_BITS (SW_SET_BITS),
    .SW_WAY_POS  (SW_WAY_POS),
    .SW_WAY_BITS (SW_WAY_BITS)
  ) u_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_fire),
    .mode  (plan.walk),
    .geom  (geom_word),
    .base  (cmd_addr),
    .size  (cmd_size),
    .adv   (adv),
    .word  (op_word),
    .last  (walk_last),
    .empty (walk_empty)
  );

  dcm_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire     (cmd_fire),
    .plan_kind    (plan.kind),
    .plan_has_ops (plan.has_ops),
    .plan_set_dc  (plan.set_dc),
    .plan_clr_dc  (plan.clr_dc),
    .plan_set_ic  (plan.set_ic),
    .plan_clr_ic  (plan.clr_ic),
    .walk_last    (walk_last),
    .walk_empty   (walk_empty),
    .op_ready     (op_ready),
    .bar_ack      (bar_ack),
    .op_valid     (op_valid),
    .op_kind      (kind_w),
    .adv          (adv),
    .bar_req      (bar_req),
    .done         (done),
    .busy         (busy),
    .cmd_ready    (cmd_ready),
    .dc_en        (dc_en),
    .ic_en        (ic_en)
  );
endmodule

// File: rtl/dcm_chk.sv
module dcm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        op_valid,
  input logic        op_ready,
  input logic [2:0]  op_kind,
  input logic [31:0] op_word,
  input logic        bar_req,
  input logic        bar_ack,
  input logic        done,
  input logic        busy,
  input logic        dc_en,
  input logic        ic_en
);
  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_word) && $stable(op_kind));
  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bar_req) && $past(bar_ack));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  bar_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_req |-> !op_valid);
  // R11
  op_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> busy && !cmd_ready);
  // R6
  dc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dc_en) |-> bar_req);
  // R7
  dc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_en) |-> busy);
  // R8
  ic_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ic_en) |-> bar_req);
endmodule

bind dcmaint_seq dcm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_kind   (op_kind),
  .op_word   (op_word),
  .bar_req   (bar_req),
  .bar_ack   (bar_ack),
  .done      (done),
  .busy      (busy),
  .dc_en     (dc_en),
  .ic_en     (ic_en)
);

// File: tb/dcmaint_seq_tb.sv
module dcmaint_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_code = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_size = '0;
  logic [3:0]  geom_sel;
  logic [31:0] geom_word = '0;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic [2:0]  op_kind;
  logic [31:0] op_word;
  logic        bar_req;
  logic        bar_ack = 1'b0;
  logic        done;
  logic        busy;
  logic        dc_en;
  logic        ic_en;

  typedef struct {
    logic [2:0]  k;
    logic [31:0] w;
    logic        dc;
    logic        ic;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int bwait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcmaint_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .geom_sel(geom_sel), .geom_word(geom_word), .op_valid(op_valid),
    .op_ready(op_ready), .op_kind(op_kind), .op_word(op_word),
    .bar_req(bar_req), .bar_ack(bar_ack), .done(done), .busy(busy),
    .dc_en(dc_en), .ic_en(ic_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Monitor: set ready for the coming edge, then score a handshake that will occur at it.
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0:       op_ready = 1'b1;
      1:       op_ready = (cyc % 3) != 0;
      default: op_ready = (cyc % 5) >= 2;
    endcase
    if (rst_n && op_valid && op_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected operation", op_word, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(op_kind == e.k, "R5", "op_kind", 32'(op_kind), 32'(e.k));
        chk(op_word == e.w, e.tag, "op_word", op_word, e.w);
        chk(dc_en == e.dc, "R6", "dc_en during op", 32'(dc_en), 32'(e.dc));
        chk(ic_en == e.ic, "R8", "ic_en during op", 32'(ic_en), 32'(e.ic));
      end
    end
  end

  // Barrier responder: acknowledge on the third cycle of a request.
  always @(negedge clk) begin
    if (bar_req) bwait++;
    else bwait = 0;
    bar_ack = bar_req && (bwait >= 3);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R10", "watchdog expired", 32'(cyc), 32'h0);
    finish_run();
  end

  function automatic logic [31:0] mkgeom(input int sets, input int ways);
    return (32'(sets - 1) << 13) | (32'(ways - 1) << 3);
  endfunction

  task automatic push_sw(input logic [2:0] k, input int sets, input int ways,
                         input logic dc, input logic ic);
    for (int s = 0; s < sets; s++) begin
      for (int w = 0; w < ways; w++) begin
        exp_t e;
        e.k = k;
        e.w = (32'(w & 3) << 30) | (32'(s & 511) << 5);
        e.dc = dc; e.ic = ic; e.tag = "R3";
        q.push_back(e);
      end
    end
  endtask

  task automatic push_va(input logic [2:0] k, input logic [31:0] addr,
                         input logic [31:0] size, input logic dc, input logic ic);
    logic [31:0] a;
    a = addr & 32'hFFFF_FFE0;
    for (int i = 0; i < int'(size / 32); i++) begin
      exp_t e;
      e.k = k; e.w = a; e.dc = dc; e.ic = ic; e.tag = "R4";
      q.push_back(e);
      a = a + 32'd32;
    end
  endtask

  task automatic push_one(input logic dc, input logic ic);
    exp_t e;
    e.k = 3'd7; e.w = 32'h0; e.dc = dc; e.ic = ic; e.tag = "R8";
    q.push_back(e);
  endtask

  task automatic run_cmd(input logic [3:0] code, input logic [31:0] addr,
                         input logic [31:0] size, input bit poke,
                         input logic exp_dc, input logic exp_ic, input string req);
    int n;
    int bar_cycles;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "ready before command", 32'(cmd_ready), 32'h1);
    cmd_code = code; cmd_addr = addr; cmd_size = size; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    bar_cycles = 0;
    while (!done && n < 5000) begin
      if (bar_req) bar_cycles++;
      if (poke && n == 2) begin
        chk(cmd_ready == 1'b0 && busy == 1'b1, "R11", "busy during sequence",
            32'(cmd_ready), 32'h0);
        cmd_code = 4'd1; cmd_valid = 1'b1;
      end
      if (poke && n == 3) cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, req, "done seen", 32'(done), 32'h1);
    chk(bar_cycles == 3, "R10", "barrier held until ack", 32'(bar_cycles), 32'd3);
    chk(q.size() == 0, req, "operations outstanding at done", 32'(q.size()), 32'h0);
    chk(dc_en == exp_dc, req, "dc_en after command", 32'(dc_en), 32'(exp_dc));
    chk(ic_en == exp_ic, req, "ic_en after command", 32'(ic_en), 32'(exp_ic));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done is a single pulse", 32'(done), 32'h0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dc_en == 0 && ic_en == 0, "R1", "enables in reset", {dc_en, ic_en}, 32'h0);
    chk(op_valid == 0 && bar_req == 0 && done == 0 && busy == 0, "R1",
        "activity in reset", {op_valid, bar_req, done, busy}, 32'h0);
    chk(cmd_ready == 1, "R1", "cmd_ready in reset", 32'(cmd_ready), 32'h1);
    chk(geom_sel == 4'b0000, "R2", "geom_sel", 32'(geom_sel), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1 && busy == 0, "R1", "idle after reset", 32'(cmd_ready), 32'h1);

    // R2 whole-cache walk, 4 sets x 2 ways, no back-pressure
    rdy_mode = 0;
    geom_word = mkgeom(4, 2);
    push_sw(3'd1, 4, 2, 1'b0, 1'b0);
    run_cmd(4'd0, 0, 0, 1'b0, 1'b0, 1'b0, "R2");

    // R9 clean-all under back-pressure
    rdy_mode = 1;
    push_sw(3'd2, 4, 2, 1'b0, 1'b0);
    run_cmd(4'd1, 0, 0, 1'b0, 1'b0, 1'b0, "R9");

    // R3 way masking: 1 set x 5 ways, way 4 wraps to 0
    rdy_mode = 2;
    geom_word = mkgeom(1, 5);
    push_sw(3'd3, 1, 5, 1'b0, 1'b0);
    run_cmd(4'd2, 0, 0, 1'b0, 1'b0, 1'b0, "R3");

    // R3 set masking: 514 sets x 1 way
    rdy_mode = 0;
    geom_word = mkgeom(514, 1);
    push_sw(3'd2, 514, 1, 1'b0, 1'b0);
    run_cmd(4'd1, 0, 0, 1'b0, 1'b0, 1'b0, "R3");

    // R4 ranges
    rdy_mode = 1;
    push_va(3'd4, 32'h1000_0013, 32'd100, 1'b0, 1'b0);
    run_cmd(4'd3, 32'h1000_0013, 32'd100, 1'b0, 1'b0, 1'b0, "R4");
    run_cmd(4'd4, 32'h2000_0000, 32'd31, 1'b0, 1'b0, 1'b0, "R4");
    push_va(3'd6, 32'h0000_0040, 32'd64, 1'b0, 1'b0);
    run_cmd(4'd5, 32'h0000_0040, 32'd64, 1'b0, 1'b0, 1'b0, "R4");

    // R6 data cache on, then on again (no effect)
    rdy_mode = 2;
    geom_word = mkgeom(4, 2);
    push_sw(3'd1, 4, 2, 1'b0, 1'b0);
    run_cmd(4'd6, 0, 0, 1'b0, 1'b1, 1'b0, "R6");
    run_cmd(4'd6, 0, 0, 1'b0, 1'b1, 1'b0, "R6");

    // R7 data cache off with a command offered while busy (R11), then off again
    rdy_mode = 1;
    push_sw(3'd3, 4, 2, 1'b0, 1'b0);
    run_cmd(4'd7, 0, 0, 1'b1, 1'b0, 1'b0, "R7");
    run_cmd(4'd7, 0, 0, 1'b0, 1'b0, 1'b0, "R7");

    // R8 instruction cache on / on again / off / invalidate-all
    rdy_mode = 0;
    push_one(1'b0, 1'b0);
    run_cmd(4'd8, 0, 0, 1'b0, 1'b0, 1'b1, "R8");
    run_cmd(4'd8, 0, 0, 1'b0, 1'b0, 1'b1, "R8");
    push_one(1'b0, 1'b0);
    run_cmd(4'd9, 0, 0, 1'b0, 1'b0, 1'b0, "R8");
    push_one(1'b0, 1'b0);
    run_cmd(4'd10, 0, 0, 1'b0, 1'b0, 1'b0, "R8");

    // R5 unassigned code completes with no operation
    run_cmd(4'd15, 0, 0, 1'b0, 1'b0, 1'b0, "R5");

    finish_run();
  end
endmodule